// File: doc/BRIEF.md
# Address-Channel Slave Grant Fabric

This block forms the address-channel request side of a four-initiator, four-target crossbar. Every initiator presents an address valid, a 32-bit address and a lock qualifier. A decoder for each initiator turns a valid address into a one-hot request aimed at one of four 4 KiB target windows. When the address lies outside all four windows, the request goes to a fallback target that answers unmapped accesses.

Each of the five targets has its own switching controller. It gathers the requests aimed at it, grants one initiator by fixed priority and holds that grant until the data or response path returns an end-of-transaction pulse. While the grant is held, the controller drives a one-hot initiator-select for the forward data paths. The same grants, transposed, give a one-hot target-select per initiator for the return paths. Each target's address ready goes back only to the initiator that target has granted.

A grant made with the lock qualifier set marks its owner as preferred. On that target's following arbitration, the owner wins even against a higher-priority initiator.

Top module: `slv_grant_fabric`

## Requirements
- R1: An address whose bits 31..14 are zero selects target number addr[13:12]. This gives windows of 0x0000_0000–0x0000_0FFF for target 0 through 0x0000_3000–0x0000_3FFF for target 3, window edges included. Any other address selects the fallback target, index 4.
- R2: An initiator whose address valid is low requests no target and receives no grant.
- R3: When several initiators request the same idle target and no lock preference applies, initiator 0 wins over 1, 1 over 2, and 2 over 3.
- R4: Target j's 4-bit select sits at t_msel[4j+3:4j], with 1000 granting initiator 0, 0100 initiator 1, 0010 initiator 2 and 0001 initiator 3. Initiator i's 5-bit select sits at m_ssel[5i+4:5i], and bit j is set while target j has granted it.
- R5: A request seen at a clock edge by an idle, non-busy target shows on the select outputs right after that edge and not before it.
- R6: While a grant is held, the target's select is constant and new requests to that target are ignored.
- R7: An end pulse seen at an edge while a grant is held clears that target's select after the edge. A still-pending request is granted at the following edge.
- R8: An idle target whose busy input is high makes no grant. The pending request is granted at the first edge after busy falls.
- R9: m_aready[i] is high exactly when a target that has granted initiator i has its address ready high. A target's ready never reaches an initiator it has not granted.
- R10: A grant made with the lock bit set sets t_locked for that target and makes its owner preferred in the target's next arbitrations. The preference stays until a grant on that target is made with the lock bit clear.
- R11: After reset every target is idle, with all selects, readies and lock flags at zero.
- R12: Accesses to the fallback target are arbitrated and held by their own controller, exactly as for a real target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_avalid | input | 4 | Address valid, bit i for initiator i |
| m_addr | input | 128 | Addresses, initiator i at [32i+31:32i] |
| m_lock | input | 4 | Lock qualifier per initiator, 1 = locked access |
| t_busy | input | 5 | Target busy status, bit 4 = fallback target |
| t_end | input | 5 | End-of-transaction pulse per target |
| t_aready | input | 5 | Address ready per target |
| m_aready | output | 4 | Routed address ready per initiator |
| t_msel | output | 20 | One-hot initiator select per target |
| m_ssel | output | 20 | One-hot target select per initiator |
| t_locked | output | 5 | Current grant on the target is locked |

## Verification
Grants, selects and lock flags are registered: a change of request, busy or end input sampled at one edge appears on the outputs right after that edge, and a request pending behind an end pulse appears one edge later. The routed ready is combinational and must follow t_aready in the same cycle. Inputs are therefore driven just after a rising edge. Registered results are read one edge later, and the ready is read after a short settle delay with no edge in between. The timing checks also confirm that no select appears before its edge.

// File: rtl/afab_pkg.sv
// Package: shared defaults and types for the address-channel grant fabric.
// Assumes: one outstanding transaction per target, fixed master count.
package afab_pkg;
    localparam int DEF_M_COUNT = 4;   // initiators
    localparam int DEF_S_COUNT = 4;   // real targets (fallback added on top)
    localparam int DEF_ADDR_W  = 32;  // address width
    localparam int DEF_WIN_W   = 12;  // log2 of one target window in bytes

    // Controller state: waiting for a request, or holding a grant.
    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_HELD = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/dec_unit.sv
// Module: dec_unit
// Turns one initiator's address into a one-hot request over S_COUNT targets
// plus a fallback target at index S_COUNT. Windows are 2**WIN_W bytes,
// contiguous from address zero. Assumes S_COUNT is a power of two.
module dec_unit #(
    parameter int S_COUNT = 4,
    parameter int ADDR_W  = 32,
    parameter int WIN_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [ADDR_W-1:0]  addr,
    output logic [S_COUNT:0]   req
);
    localparam int IDX_W = (S_COUNT > 1) ? $clog2(S_COUNT) : 1;
    localparam int TOP_L = WIN_W + IDX_W;

    logic               upper_zero;
    logic [IDX_W-1:0]   win_idx;
    logic [S_COUNT-1:0] hit;

    // Address split: everything above the window index must be zero.
    assign upper_zero = (addr[ADDR_W-1:TOP_L] == '0);
    assign win_idx    = addr[WIN_W +: IDX_W];

    // One comparator per real target window.
    for (genvar s = 0; s < S_COUNT; s++) begin : g_win
        assign hit[s] = valid && upper_zero && (win_idx == IDX_W'(s));
    end

    // Request vector: real hits, fallback when valid but nothing matched.
    assign req[S_COUNT-1:0] = hit;
    assign req[S_COUNT]     = valid && !(|hit);

    // R2: a valid address always produces exactly one request bit.
    a_r2_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $onehot(req));
    // R2: no request without valid.
    a_r2_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (req == '0));
endmodule

// File: rtl/prio_pick.sv
// Module: prio_pick
// Picks the lowest-index requester (index 0 is highest priority), unless a
// preferred index is flagged and currently requesting, in which case that
// one wins. Pure combinational.
module prio_pick #(
    parameter int N    = 4,
    parameter int IW   = 2
) (
    input  logic [N-1:0]  req,
    input  logic          pref_vld,
    input  logic [IW-1:0] pref_idx,
    output logic          any,
    output logic [IW-1:0] win
);
    logic [IW-1:0] fixed_win;

    // Fixed-priority search: lower index overrides higher.
    always_comb begin
        fixed_win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) fixed_win = IW'(i);
        end
    end

    // Preference override for a lock owner that is requesting again.
    always_comb begin
        any = |req;
        win = (pref_vld && req[pref_idx]) ? pref_idx : fixed_win;
    end
endmodule

// File: rtl/switch_ctrl.sv
// Module: switch_ctrl
// One per target. Grants a single initiator, holds the grant until an end
// pulse, and keeps a lock owner preferred for later arbitrations.
// msel bit (M_COUNT-1-i) stands for initiator i (MSB = initiator 0).
// Assumes end_p is only meaningful while a grant is held.
module switch_ctrl
    import afab_pkg::*;
#(
    parameter int M_COUNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [M_COUNT-1:0] req,
    input  logic [M_COUNT-1:0] lock,
    input  logic               busy,
    input  logic               end_p,
    output logic [M_COUNT-1:0] msel,
    output logic               locked
);
    localparam int IW = (M_COUNT > 1) ? $clog2(M_COUNT) : 1;

    ctl_state_e         state;
    logic               hold_vld;
    logic [IW-1:0]      hold_idx;
    logic               any_req;
    logic [IW-1:0]      pick;
    logic [M_COUNT-1:0] pick_vec;

    prio_pick #(.N(M_COUNT), .IW(IW)) u_pick (
        .req      (req),
        .pref_vld (hold_vld),
        .pref_idx (hold_idx),
        .any      (any_req),
        .win      (pick)
    );

    // Select code for the winner, MSB-first initiator order.
    always_comb begin
        pick_vec = '0;
        pick_vec[(M_COUNT - 1) - int'(pick)] = 1'b1;
    end

    // Grant, hold and release sequencing plus lock-owner bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CTL_IDLE;
            msel     <= '0;
            locked   <= 1'b0;
            hold_vld <= 1'b0;
            hold_idx <= '0;
        end else begin
            case (state)
                CTL_IDLE: begin
                    if (any_req && !busy) begin
                        state    <= CTL_HELD;
                        msel     <= pick_vec;
                        locked   <= lock[pick];
                        hold_vld <= lock[pick];
                        hold_idx <= pick;
                    end
                end
                CTL_HELD: begin
                    if (end_p) begin
                        state  <= CTL_IDLE;
                        msel   <= '0;
                        locked <= 1'b0;
                    end
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end

    // R4: at most one initiator selected at a time.
    a_r4_msel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(msel));
    // R6: a held grant does not move without an end pulse.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_HELD && !end_p) |=> $stable(msel));
    // R7: end pulse releases the target.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_HELD && end_p) |=> (msel == '0));
    // R8: busy idle target makes no grant.
    a_r8_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_IDLE && busy) |=> (msel == '0));
    // R5: a new grant always traces back to a request.
    a_r5_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|msel) |-> $past(|req));
endmodule

// File: rtl/ready_route.sv
// Module: ready_route
// Returns each target's address ready to the initiator it has granted:
// AND with the select bit, then OR over targets per initiator.
// Assumes an initiator holds at most one grant at a time.
module ready_route #(
    parameter int M_COUNT = 4,
    parameter int T_COUNT = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [T_COUNT-1:0]         t_aready,
    input  logic [T_COUNT*M_COUNT-1:0] t_msel,
    output logic [M_COUNT-1:0]         m_aready
);
    for (genvar i = 0; i < M_COUNT; i++) begin : g_mst
        logic [T_COUNT-1:0] col;
        // Column of select bits that point at initiator i.
        for (genvar j = 0; j < T_COUNT; j++) begin : g_col
            assign col[j] = t_msel[j*M_COUNT + (M_COUNT-1-i)];
        end
        // AND-OR return of the ready.
        assign m_aready[i] = |(col & t_aready);

        // R9: only one target's ready can reach this initiator.
        a_r9_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col & t_aready) <= 1);
    end
endmodule

// File: rtl/slv_grant_fabric.sv
// Module: slv_grant_fabric (top)
// Address-channel request fabric: per-initiator decoders, per-target
// switching controllers (fallback target last), select transposition and
// ready return. Flat vectors: initiator i / target j slices as in the brief.
module slv_grant_fabric
    import afab_pkg::*;
#(
    parameter int M_COUNT = DEF_M_COUNT,
    parameter int S_COUNT = DEF_S_COUNT,
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int WIN_W   = DEF_WIN_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [M_COUNT-1:0]               m_avalid,
    input  logic [M_COUNT*ADDR_W-1:0]        m_addr,
    input  logic [M_COUNT-1:0]               m_lock,
    input  logic [S_COUNT:0]                 t_busy,
    input  logic [S_COUNT:0]                 t_end,
    input  logic [S_COUNT:0]                 t_aready,
    output logic [M_COUNT-1:0]               m_aready,
    output logic [(S_COUNT+1)*M_COUNT-1:0]   t_msel,
    output logic [M_COUNT*(S_COUNT+1)-1:0]   m_ssel,
    output logic [S_COUNT:0]                 t_locked
);
    localparam int T_COUNT = S_COUNT + 1;

    logic [T_COUNT-1:0] req_by_m [M_COUNT];
    logic [M_COUNT-1:0] req_by_t [T_COUNT];

    // One address decoder per initiator.
    for (genvar i = 0; i < M_COUNT; i++) begin : g_dec
        dec_unit #(.S_COUNT(S_COUNT), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (m_avalid[i]),
            .addr  (m_addr[i*ADDR_W +: ADDR_W]),
            .req   (req_by_m[i])
        );
    end

    // Regroup requests by target and build one controller per target.
    for (genvar j = 0; j < T_COUNT; j++) begin : g_tgt
        for (genvar i = 0; i < M_COUNT; i++) begin : g_gather
            assign req_by_t[j][i] = req_by_m[i][j];
        end
        switch_ctrl #(.M_COUNT(M_COUNT)) u_ctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_by_t[j]),
            .lock   (m_lock),
            .busy   (t_busy[j]),
            .end_p  (t_end[j]),
            .msel   (t_msel[j*M_COUNT +: M_COUNT]),
            .locked (t_locked[j])
        );
    end

    // Transpose: per-initiator target select for the return paths.
    for (genvar i = 0; i < M_COUNT; i++) begin : g_ssel
        for (genvar j = 0; j < T_COUNT; j++) begin : g_bit
            assign m_ssel[i*T_COUNT + j] = t_msel[j*M_COUNT + (M_COUNT-1-i)];
        end
    end

    ready_route #(.M_COUNT(M_COUNT), .T_COUNT(T_COUNT)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .t_aready (t_aready),
        .t_msel   (t_msel),
        .m_aready (m_aready)
    );

    // R11: selects are clear on the first cycle after reset is released.
    a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (t_msel == '0 && t_locked == '0));
endmodule

// File: tb/sim_slv_grant_fabric.sv
// Bench for slv_grant_fabric: vector table walk, then directed tests.
module sim_slv_grant_fabric;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   m_avalid = '0;
    logic [127:0] m_addr = '0;
    logic [3:0]   m_lock = '0;
    logic [4:0]   t_busy = '0;
    logic [4:0]   t_end = '0;
    logic [4:0]   t_aready = '0;
    logic [3:0]   m_aready;
    logic [19:0]  t_msel;
    logic [19:0]  m_ssel;
    logic [4:0]   t_locked;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    slv_grant_fabric u0 (
        .clk(clk), .rst_n(rst_n), .m_avalid(m_avalid), .m_addr(m_addr),
        .m_lock(m_lock), .t_busy(t_busy), .t_end(t_end), .t_aready(t_aready),
        .m_aready(m_aready), .t_msel(t_msel), .m_ssel(m_ssel), .t_locked(t_locked)
    );

    // Vector: [35:32] valid, [31:20] 3-bit address code per initiator,
    // [19:0] expected t_msel one edge after the stimulus.
    localparam logic [35:0] VEC [9] = '{
        {4'h1, 12'h001, 20'h00080},   // R1 m0 -> t1
        {4'hF, 12'h492, 20'h00800},   // R3 all -> t2, m0 wins
        {4'hE, 12'h6D8, 20'h04000},   // R3 m1..m3 -> t3, m1 wins
        {4'hF, 12'h688, 20'h01248},   // R1 R4 each to own target
        {4'hC, 12'hB00, 20'h20000},   // R12 m2,m3 -> fallback, m2 wins
        {4'h9, 12'hE06, 20'h01008},   // R1 window edges
        {4'h0, 12'h492, 20'h00000},   // R2 no valid, no grant
        {4'h8, 12'h000, 20'h00001},   // R4 m3 -> t0
        {4'h6, 12'h160, 20'h40000}    // R12 R3 m1,m2 -> fallback, m1 wins
    };

    function automatic logic [31:0] code_addr(input logic [2:0] c);
        case (c)
            3'd4:    return 32'h0000_4000;
            3'd5:    return 32'hFFFF_F000;
            3'd6:    return 32'h0000_0FFF;
            3'd7:    return 32'h0000_3FFF;
            default: return {18'd0, c[1:0], 12'hABC};
        endcase
    endfunction

    // Expected per-initiator select, derived from R4's layout.
    function automatic logic [19:0] ssel_of(input logic [19:0] ms);
        logic [19:0] r = '0;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 5; j++)
                r[i*5 + j] = ms[j*4 + (3 - i)];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input int m, input logic [31:0] a);
        m_addr[m*32 +: 32] = a;
        m_avalid[m] = 1'b1;
    endtask

    task automatic release_all();
        m_avalid = '0;
        m_lock = '0;
        t_end = '1;
        tick();
        t_end = '0;
        tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_aready = '1;
        tick();
        tick();
        // R11: reset state
        chk("R11 msel", 32'(t_msel), 32'h0);
        chk("R11 ssel", 32'(m_ssel), 32'h0);
        chk("R11 aready", 32'(m_aready), 32'h0);
        chk("R11 locked", 32'(t_locked), 32'h0);
        rst_n = 1'b1;
        t_aready = '0;
        tick();

        // Table walk
        for (int v = 0; v < 9; v++) begin
            for (int m = 0; m < 4; m++)
                m_addr[m*32 +: 32] = code_addr(VEC[v][20 + 3*m +: 3]);
            m_avalid = VEC[v][35:32];
            tick();
            chk($sformatf("R1 R3 R4 vec%0d msel", v), 32'(t_msel), 32'(VEC[v][19:0]));
            chk($sformatf("R4 vec%0d ssel", v), 32'(m_ssel), 32'(ssel_of(VEC[v][19:0])));
            release_all();
        end

        // R5: grant appears only after the edge
        put(0, 32'h0000_0010);
        #1;
        chk("R5 before edge", 32'(t_msel[3:0]), 32'h0);
        tick();
        chk("R5 after edge", 32'(t_msel[3:0]), 32'h8);
        // R9: ready return
        t_aready = 5'b00001;
        #1;
        chk("R9 routed", 32'(m_aready), 32'h1);
        t_aready = 5'b11110;
        #1;
        chk("R9 not routed", 32'(m_aready), 32'h0);
        t_aready = '0;

        // R6: held grant ignores a new request
        m_avalid = '0;
        put(1, 32'h0000_0020);
        tick();
        tick();
        chk("R6 hold", 32'(t_msel[3:0]), 32'h8);
        // R7: end releases, pending request granted one edge later
        t_end = 5'b00001;
        tick();
        t_end = '0;
        chk("R7 released", 32'(t_msel[3:0]), 32'h0);
        tick();
        chk("R7 regrant", 32'(t_msel[3:0]), 32'h4);
        release_all();

        // R8: busy blocks grant
        t_busy = 5'b00100;
        put(2, 32'h0000_2000);
        tick();
        tick();
        chk("R8 busy", 32'(t_msel[11:8]), 32'h0);
        t_busy = '0;
        tick();
        chk("R8 after busy", 32'(t_msel[11:8]), 32'h2);
        release_all();

        // R10: lock owner preference on target 1
        put(3, 32'h0000_1000);
        m_lock = 4'b1000;
        tick();
        chk("R10 locked grant", 32'(t_msel[7:4]), 32'h1);
        chk("R10 locked flag", 32'(t_locked), 32'h02);
        release_all();
        put(0, 32'h0000_1004);
        put(3, 32'h0000_1000);
        m_lock = 4'b1000;
        tick();
        chk("R10 owner beats m0", 32'(t_msel[7:4]), 32'h1);
        release_all();
        put(0, 32'h0000_1004);
        put(3, 32'h0000_1000);
        tick();
        chk("R10 owner normal", 32'(t_msel[7:4]), 32'h1);
        chk("R10 flag clear", 32'(t_locked), 32'h0);
        release_all();
        put(0, 32'h0000_1004);
        put(3, 32'h0000_1000);
        tick();
        chk("R10 preference gone", 32'(t_msel[7:4]), 32'h8);
        release_all();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule